// File: doc/BRIEF.md
# Periodic Interrupt Timer Unit

This block generates a periodic interrupt from a 16-bit modulus counter that counts down. Software programs a reload register with the period and sets bits in a control/status register. The block sees the slow timer clock as a one-cycle count-enable pulse on `tick`. Each time the counter expires, the block sets a sticky status flag. That flag drives a single level-sensitive interrupt line whenever the interrupt-enable bit is also set.

Software reaches both registers through a single-cycle write strobe with a one-bit register select, and a combinational read path. Clearing the run bit freezes the counter where it is. Setting it again resumes counting from the frozen value. A value written to the reload register while the timer is stopped goes straight into the counter, so the next period after enabling uses the new value. The frequency-select bit is only stored and read back; it tells software which slow clock drives `tick`.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, both registers read 0x0000 and `irq` is low.
- R2: With `reg_sel` = 1, the reload register is a 16-bit register that can be written and read back.
- R3: With `reg_sel` = 0, the control/status register uses LSB-0 bit positions: bit 0 is run, bit 1 is frequency select, bit 2 is interrupt enable and bit 7 is the sticky status. Bits 0 to 2 can be written and read back. Bits 3 to 6 and 8 to 15 always read 0.
- R4: When run = 1, each cycle with `tick` high does one of two things. If the counter is nonzero, it decrements by one; the step from 1 to 0 sets status. If the counter is zero, it reloads from the reload register. A reload value N > 0 therefore gives one status event every N+1 ticks.
- R5: When run = 0, the counter holds its value and ticks never set status. Setting run to 1 again resumes from the held value with no reload.
- R6: A control write with bit 7 = 1 clears status. A control write with bit 7 = 0 leaves status unchanged.
- R7: `irq` is high exactly while status = 1 and interrupt enable = 1.
- R8: A reload-register write while run = 0 also loads the counter. A reload-register write while run = 1 does not change the counter.
- R9: With a reload value of 0, every enabled tick sets status and the counter stays at 0.
- R10: If status is set by the counter and cleared by a write in the same cycle, status ends up as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count enable from the slow timer clock |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 is control/status, 1 is reload |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions check the following on every cycle:
- the counter steps down by one per enabled tick;
- the counter reloads from zero;
- the counter freezes when stopped;
- the counter loads directly when the reload register is written while stopped;
- status stays set unless a write-one arrives, and a counter set wins over that clear;
- the reserved control bits read as zero.

Some behaviours show only at the ports over a sequence of operations, so only the bench scenarios can demonstrate them:
- the exact N+1-tick period;
- resuming without a reload after a stop;
- `irq` following the enable bit;
- the zero-reload case;
- a return to the reset state partway through a run.

// File: rtl/ptt_pkg.sv
// Shared constants and types for the periodic tick timer.
// Assumes a register data width of at least 8 bits.
package ptt_pkg;
    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_FSEL = 1;
    localparam int unsigned BIT_IEN  = 2;
    localparam int unsigned BIT_STAT = 7;

    typedef enum logic {
        SEL_CTRL   = 1'b0,
        SEL_RELOAD = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic stat;
        logic ien;
        logic fsel;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/ptt_ctrl_reg.sv
// Control/status register of the timer. Holds the run, frequency-select
// and interrupt-enable bits plus the sticky status flag. A counter set of
// status takes priority over a write-one clear in the same cycle.
// Assumes: wr is a single-cycle strobe already decoded for this register.
module ptt_ctrl_reg
    import ptt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  logic  w_run,
    input  logic  w_fsel,
    input  logic  w_ien,
    input  logic  w_stat_clr,
    input  logic  set_stat,
    output ctrl_t ctrl
);
    // Configuration bits: reset to zero, loaded on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.run  <= 1'b0;
            ctrl.fsel <= 1'b0;
            ctrl.ien  <= 1'b0;
        end else if (wr) begin
            ctrl.run  <= w_run;
            ctrl.fsel <= w_fsel;
            ctrl.ien  <= w_ien;
        end
    end

    // Sticky status: a counter set wins, otherwise a write-one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.stat <= 1'b0;
        end else if (set_stat) begin
            ctrl.stat <= 1'b1;
        end else if (wr && w_stat_clr) begin
            ctrl.stat <= 1'b0;
        end
    end
endmodule

// File: rtl/ptt_down_counter.sv
// Modulus down-counter. When enabled it steps once per tick and reloads
// on the tick after it reaches zero. It flags expiry on the step from 1 to
// 0, and on every enabled tick when the reload value is zero.
// Assumes: load_now is only raised while the counter is not running.
module ptt_down_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         load_now,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic step;
    assign step = run && tick;

    // Expiry request toward the status flag.
    always_comb begin
        expire = step && ((cnt == ONE) || ((cnt == '0) && (reload == '0)));
    end

    // Count state: decrement, reload from zero, or direct load while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            if (cnt == '0) begin
                cnt <= reload;
            end else begin
                cnt <= cnt - ONE;
            end
        end else if (load_now) begin
            cnt <= load_val;
        end
    end
endmodule

// File: rtl/periodic_tick_timer.sv
// Top level of the periodic interrupt timer. Decodes writes to the two
// registers, holds the reload value, muxes read data and gates the
// interrupt. Assumes W >= 8 so the control fields fit the data bus.
module periodic_tick_timer
    import ptt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic         reg_sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         irq
);
    ctrl_t        ctrl_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] cnt_q;
    logic         expire;
    logic         wr_ctrl;
    logic         wr_reload;
    logic         run_q;
    logic         stat_q;

    assign wr_ctrl   = wr_en && (reg_sel == SEL_CTRL);
    assign wr_reload = wr_en && (reg_sel == SEL_RELOAD);
    assign run_q     = ctrl_q.run;
    assign stat_q    = ctrl_q.stat;

    // Reload register: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_reload) begin
            reload_q <= wdata;
        end
    end

    ptt_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_ctrl),
        .w_run      (wdata[BIT_RUN]),
        .w_fsel     (wdata[BIT_FSEL]),
        .w_ien      (wdata[BIT_IEN]),
        .w_stat_clr (wdata[BIT_STAT]),
        .set_stat   (expire),
        .ctrl       (ctrl_q)
    );

    ptt_down_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (ctrl_q.run),
        .load_now (wr_reload && !ctrl_q.run),
        .load_val (wdata),
        .reload   (reload_q),
        .cnt      (cnt_q),
        .expire   (expire)
    );

    // Read mux: control fields at fixed positions, reserved bits zero.
    always_comb begin
        rdata = '0;
        if (reg_sel == SEL_RELOAD) begin
            rdata = reload_q;
        end else begin
            rdata[BIT_RUN]  = ctrl_q.run;
            rdata[BIT_FSEL] = ctrl_q.fsel;
            rdata[BIT_IEN]  = ctrl_q.ien;
            rdata[BIT_STAT] = ctrl_q.stat;
        end
    end

    // Interrupt gating.
    assign irq = ctrl_q.stat && ctrl_q.ien;
endmodule

// File: rtl/ptt_chk.sv
// Property checker for periodic_tick_timer, attached through bind.
// Observes the ports plus the counter, reload and control state.
module ptt_chk
    import ptt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr_en,
    input logic         reg_sel,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] reload_q,
    input logic [W-1:0] cnt_q,
    input logic         run_q,
    input logic         stat_q
);
    localparam logic [W-1:0] ONE = W'(1);

    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && (cnt_q > ONE)) |=> (cnt_q == $past(cnt_q) - ONE));

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && (cnt_q == '0)) |=> (cnt_q == $past(reload_q)));

    a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !(wr_en && reg_sel == SEL_RELOAD)) |=> $stable(cnt_q));

    a_r8_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && wr_en && reg_sel == SEL_RELOAD) |=> (cnt_q == $past(wdata)));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && ((cnt_q == ONE) || (cnt_q == '0 && reload_q == '0)))
        |=> stat_q);

    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(wr_en && reg_sel == SEL_CTRL && wdata[BIT_STAT])) |=> stat_q);

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_CTRL) |-> ((rdata[W-1:8] == '0) && (rdata[6:3] == '0)));
endmodule

bind periodic_tick_timer ptt_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .reg_sel  (reg_sel),
    .wdata    (wdata),
    .rdata    (rdata),
    .reload_q (reload_q),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .stat_q   (stat_q)
);

// File: tb/periodic_tick_timer_tb.sv
module periodic_tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    periodic_tick_timer #(.W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Vector fields: req[3:0] op[1:0] sel val[15:0] exp[15:0]
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;
    localparam int NV = 34;
    localparam logic [38:0] VEC [NV] = '{
        {4'd1,  OP_RD,  1'b0, 16'h0000, 16'h0000}, // R1 ctrl after reset
        {4'd1,  OP_RD,  1'b1, 16'h0000, 16'h0000}, // R1 reload after reset
        {4'd1,  OP_IRQ, 1'b0, 16'h0000, 16'h0000}, // R1 irq low
        {4'd8,  OP_WR,  1'b1, 16'h0003, 16'h0000}, // R8 load while stopped
        {4'd2,  OP_RD,  1'b1, 16'h0000, 16'h0003}, // R2 readback
        {4'd3,  OP_WR,  1'b0, 16'hFFFF, 16'h0000}, // R3 all ones
        {4'd3,  OP_RD,  1'b0, 16'h0000, 16'h0007}, // R3 reserved zero
        {4'd4,  OP_TK,  1'b0, 16'd2,    16'h0000}, // R4 3->1
        {4'd4,  OP_RD,  1'b0, 16'h0000, 16'h0007}, // R4 not yet
        {4'd7,  OP_IRQ, 1'b0, 16'h0000, 16'h0000}, // R7 no irq
        {4'd4,  OP_TK,  1'b0, 16'd1,    16'h0000}, // R4 1->0
        {4'd4,  OP_RD,  1'b0, 16'h0000, 16'h0087}, // R4 status set
        {4'd7,  OP_IRQ, 1'b0, 16'h0000, 16'h0001}, // R7 irq high
        {4'd6,  OP_WR,  1'b0, 16'h0003, 16'h0000}, // R6 write zero to status
        {4'd6,  OP_RD,  1'b0, 16'h0000, 16'h0083}, // R6 status kept
        {4'd7,  OP_IRQ, 1'b0, 16'h0000, 16'h0000}, // R7 gated off
        {4'd6,  OP_WR,  1'b0, 16'h0083, 16'h0000}, // R6 write one clears
        {4'd6,  OP_RD,  1'b0, 16'h0000, 16'h0003}, // R6 cleared
        {4'd4,  OP_TK,  1'b0, 16'd3,    16'h0000}, // R4 0->3->2->1
        {4'd4,  OP_RD,  1'b0, 16'h0000, 16'h0003}, // R4 period not done
        {4'd4,  OP_TK,  1'b0, 16'd1,    16'h0000}, // R4 1->0
        {4'd4,  OP_RD,  1'b0, 16'h0000, 16'h0083}, // R4 period N+1
        {4'd6,  OP_WR,  1'b0, 16'h0083, 16'h0000}, // R6 clear
        {4'd8,  OP_WR,  1'b1, 16'h0005, 16'h0000}, // R8 write while running
        {4'd4,  OP_TK,  1'b0, 16'd3,    16'h0000}, // R4 0->5->4->3
        {4'd5,  OP_WR,  1'b0, 16'h0000, 16'h0000}, // R5 stop
        {4'd5,  OP_TK,  1'b0, 16'd9,    16'h0000}, // R5 frozen ticks
        {4'd5,  OP_RD,  1'b0, 16'h0000, 16'h0000}, // R5 no status
        {4'd5,  OP_WR,  1'b0, 16'h0001, 16'h0000}, // R5 restart
        {4'd5,  OP_TK,  1'b0, 16'd2,    16'h0000}, // R5 3->1
        {4'd5,  OP_RD,  1'b0, 16'h0000, 16'h0001}, // R5 no reload on resume
        {4'd5,  OP_TK,  1'b0, 16'd1,    16'h0000}, // R5 1->0
        {4'd5,  OP_RD,  1'b0, 16'h0000, 16'h0081}, // R5 expiry from held value
        {4'd2,  OP_RD,  1'b1, 16'h0000, 16'h0005}  // R2 reload value kept
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input string req, input logic sel, input logic [15:0] exp);
        @(negedge clk);
        reg_sel = sel;
        #1 check(req, rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][38:35], i);
            case (VEC[i][34:33])
                OP_WR:  wr(VEC[i][32], VEC[i][31:16]);
                OP_RD:  rd(tag, VEC[i][32], VEC[i][15:0]);
                OP_TK:  ticks(int'(VEC[i][31:16]));
                default: begin
                    @(negedge clk);
                    #1 check(tag, {15'd0, irq}, VEC[i][15:0]);
                end
            endcase
        end

        // R10: counter set and write-one clear in one cycle; set must win.
        wr(1'b0, 16'h0000);           // stop, status stays 1
        wr(1'b1, 16'h0001);           // counter loads 1
        wr(1'b0, 16'h0001);           // run
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; reg_sel = 1'b0; wdata = 16'h0081;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; wdata = '0;
        rd("R10 set beats clear", 1'b0, 16'h0081);
        wr(1'b0, 16'h0081);
        rd("R6 clear after collision", 1'b0, 16'h0001);

        // R9: zero reload value expires on every enabled tick.
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'h0005);
        ticks(1);
        rd("R9 first zero expiry", 1'b0, 16'h0085);
        @(negedge clk);
        #1 check("R7 irq with zero reload", {15'd0, irq}, 16'h0001);
        wr(1'b0, 16'h0085);
        rd("R9 cleared", 1'b0, 16'h0005);
        ticks(1);
        rd("R9 second zero expiry", 1'b0, 16'h0085);
        wr(1'b0, 16'h0084);           // stop and clear
        ticks(3);
        rd("R5 stopped ticks set nothing", 1'b0, 16'h0004);

        // R1: reset in the middle of operation.
        wr(1'b0, 16'h0007);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd("R1 ctrl after mid reset", 1'b0, 16'h0000);
        rd("R1 reload after mid reset", 1'b1, 16'h0000);
        #1 check("R1 irq after mid reset", {15'd0, irq}, 16'h0000);

        summary();
    end
endmodule